// File: doc/BRIEF.md
# Framed Serial Pixel Word Serializer

This block turns a stream of 14-bit pixel words into a single serial bit stream. Each pixel gets a slot of 16 bit-times. A bit-time passes on every clock cycle in which the bit-time strobe is high. The 14 data bits sit in the middle of the slot with one guard bit-time on each side, so a small drift in the receiving clock cannot cut off a data bit. Alongside the data the block drives a frame flag that marks where each word starts. It also drives a forwarded clock phase that toggles once per bit-time, so one clock period covers two bit-times and the receiver captures on both edges.

The length of the frame pulse carries sampling-path information. In sample-and-hold mode every pixel gets a pulse of three forwarded-clock periods. In correlated double sampling mode the pixels alternate between the even and odd sampling paths. Even pixels get a two-period pulse and odd pixels a three-period pulse, so downstream logic can correct a per-path offset.

Words enter through a valid/ready handshake backed by one holding register. The source may present a word at any time. `in_ready` is high while the holding register is empty. A word is taken on a cycle where `in_valid` and `in_ready` are both high, and it waits in the register until the current slot ends. While the register is full, `in_ready` is low and the source must hold its word and keep `in_valid` high. Words are never dropped.

Top module: `pixel_word_serializer`

## Requirements
- R1: `in_ready` is high exactly when the one-word holding register is empty. A word is accepted on a clock where `in_valid` and `in_ready` are both high. When the register is full, `in_ready` is low until the held word moves into a slot.
- R2: A slot lasts 16 bit-times, and each bit-time is one clock cycle with `bit_en` high. While the holding register stays filled, slots follow each other with no gap, so consecutive frame rises are exactly 16 bit-times apart.
- R3: Slot layout by bit-time: position 0 is a guard bit, positions 1 to 14 carry word bits 13 down to 0 (most significant first), and position 15 is a guard bit. `ser_bit` is 0 in both guard positions.
- R4: `frame_out` rises in the same bit-time in which `ser_bit` presents word bit 13.
- R5: In sample-and-hold mode (`mode_cds` = 0), `frame_out` stays high for 6 bit-times (3 forwarded-clock periods) and falls when word bit 7 is presented, on every pixel.
- R6: In correlated double sampling mode (`mode_cds` = 1), pixels alternate even, odd, even, and so on. Even pixels have `frame_out` high for 4 bit-times (it falls when bit 9 is presented). Odd pixels have it high for 6 bit-times. The first pixel sent in this mode after reset is even. The mode is sampled when a word enters its slot.
- R7: `fclk_out` inverts on every bit-time (every clock with `bit_en` high) and is otherwise unchanged.
- R8: While `rst_n` is low and right after reset: `ser_bit`, `frame_out` and `fclk_out` are 0, `in_ready` is 1, and no slot is active.
- R9: A word accepted while a slot is running does not start until that slot's position 15 has been sent. When no word is pending at a slot boundary, the block goes idle and holds `ser_bit` and `frame_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-time strobe; each high cycle advances the slot by one bit |
| in_valid | input | 1 | Source offers a pixel word |
| in_ready | output | 1 | Holding register can take a word |
| in_word | input | 14 | Pixel word |
| mode_cds | input | 1 | 0 = sample-and-hold, 1 = correlated double sampling |
| ser_bit | output | 1 | Serial data bit for the current bit-time |
| frame_out | output | 1 | Frame flag marking the start of the word and its sampling path |
| fclk_out | output | 1 | Forwarded clock phase, toggles every bit-time |

## Verification
The assertions watch the following on every cycle:
- the forwarded clock inverts on every bit-time;
- the guard positions drive 0;
- the frame flag rises only at the MSB position and falls only at one of the two allowed positions;
- the slot position steps by one per bit-time;
- a held word stays unchanged until it is consumed.

Only the bench scenarios can show the end-to-end results:
- the serial bits reassemble into the word that was sent;
- the pulse widths alternate 4, 6, 4, 6 from even after reset;
- back-to-back words start exactly 16 bit-times apart;
- a word offered during a busy slot stalls on `in_ready` without being lost.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam int WORD_W      = 14;
  localparam int SLOT_BITS   = 16;
  localparam int LEAD_GUARD  = 1;
  localparam int BITS_PER_CK = 2;
  localparam int LONG_CKS    = 3;
  localparam int SHORT_CKS   = 2;
  localparam int POS_W       = $clog2(SLOT_BITS);
  localparam int LONG_BITS   = LONG_CKS * BITS_PER_CK;
  localparam int SHORT_BITS  = SHORT_CKS * BITS_PER_CK;
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(LEAD_GUARD);
  localparam logic [POS_W-1:0] POS_DEND  = POS_W'(LEAD_GUARD + WORD_W);
  localparam logic [POS_W-1:0] POS_LONG  = POS_W'(LEAD_GUARD + LONG_BITS);
  localparam logic [POS_W-1:0] POS_SHORT = POS_W'(LEAD_GUARD + SHORT_BITS);
endpackage

// File: rtl/pws_hold.sv
module pws_hold
  import pws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              take,
  output logic              full,
  output logic [WORD_W-1:0] word
);
  logic accept;
  assign in_ready = !full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        word <= in_word;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    full && !take |=> full && $stable(word)); // R1
  AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full); // R1
endmodule

// File: rtl/pws_slot.sv
module pws_slot
  import pws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             pending,
  input  logic             mode_cds,
  output logic             load,
  output logic             active,
  output logic [POS_W-1:0] pos,
  output logic             tag_short,
  output logic             fclk
);
  logic parity_odd;
  logic boundary;

  assign boundary = !active || (pos == POS_LAST);
  assign load     = bit_en && boundary && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      pos        <= '0;
      tag_short  <= 1'b0;
      parity_odd <= 1'b0;
      fclk       <= 1'b0;
    end else if (bit_en) begin
      fclk <= ~fclk;
      if (boundary) begin
        active <= pending;
        pos    <= '0;
        if (pending) begin
          tag_short <= mode_cds && !parity_odd;
          if (mode_cds) parity_odd <= ~parity_odd;
        end
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  AST_FCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> fclk != $past(fclk)); // R7
  AST_FCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(fclk)); // R7
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active && bit_en && pos != POS_LAST |=> active && pos == $past(pos) + 1'b1); // R2
  AST_IDLE_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && pos == POS_LAST && !pending |=> !active); // R9
endmodule

// File: rtl/pws_format.sv
module pws_format
  import pws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              active,
  input  logic [POS_W-1:0]  pos,
  input  logic              tag_short,
  output logic              ser_bit,
  output logic              frame_out
);
  logic [WORD_W-1:0] word_q;
  logic [POS_W-1:0]  frame_end;
  logic              in_data;
  logic [POS_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= word_in;
  end

  assign in_data   = active && (pos >= POS_FIRST) && (pos < POS_DEND);
  assign idx       = POS_DEND - 1'b1 - pos;
  assign ser_bit   = in_data ? word_q[idx] : 1'b0;
  assign frame_end = tag_short ? POS_SHORT : POS_LONG;
  assign frame_out = active && (pos >= POS_FIRST) && (pos < frame_end);

  AST_GUARD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    active && (pos == '0 || pos == POS_LAST) |-> !ser_bit); // R3
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_out) |-> active && pos == POS_FIRST); // R4
  AST_FRAME_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_out) && active |-> pos == POS_SHORT || pos == POS_LONG); // R5 R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !ser_bit && !frame_out); // R9
endmodule

// File: rtl/pixel_word_serializer.sv
module pixel_word_serializer
  import pws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              mode_cds,
  output logic              ser_bit,
  output logic              frame_out,
  output logic              fclk_out
);
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;
  logic              load;
  logic              active;
  logic [POS_W-1:0]  pos;
  logic              tag_short;

  pws_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .take(load), .full(hold_full), .word(hold_word)
  );

  pws_slot u_slot (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pending(hold_full),
    .mode_cds(mode_cds), .load(load), .active(active), .pos(pos),
    .tag_short(tag_short), .fclk(fclk_out)
  );

  pws_format u_fmt (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(hold_word),
    .active(active), .pos(pos), .tag_short(tag_short),
    .ser_bit(ser_bit), .frame_out(frame_out)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !ser_bit && !frame_out && !fclk_out && in_ready); // R8
endmodule

// File: tb/pixel_word_serializer_tb.sv
module pixel_word_serializer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_word = '0;
  logic        mode_cds = 1'b0;
  logic        ser_bit, frame_out, fclk_out;

  int vectors = 0;
  int errors = 0;

  pixel_word_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .mode_cds(mode_cds),
    .ser_bit(ser_bit), .frame_out(frame_out), .fclk_out(fclk_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor records of frames seen
  int          nrec = 0;
  logic [13:0] rec_word [16];
  int          rec_len  [16];
  int          rec_start[16];
  bit          rec_lead [16];
  bit          rec_trail[16];
  int          bitn = 0;
  int          fclk_err = 0;
  int          cap = 0;
  logic [13:0] cw;
  int          flen;
  bit          lead_ok;
  logic        prev_ser = 0, prev_frame = 0, prev_fclk = 0;
  bit          have_prev = 0;

  always @(negedge clk) begin
    if (rst_n && bit_en) begin
      bitn++;
      if (have_prev && fclk_out == prev_fclk) fclk_err++;
      if (cap == 0 && frame_out && !prev_frame) begin
        cap = 1; cw = {13'b0, ser_bit}; flen = 1;
        lead_ok = (prev_ser == 1'b0);
        if (nrec < 16) rec_start[nrec] = bitn;
      end else if (cap >= 1 && cap < 14) begin
        cap++; cw = {cw[12:0], ser_bit};
        if (frame_out) flen++;
      end else if (cap == 14) begin
        if (nrec < 16) begin
          rec_word[nrec] = cw; rec_len[nrec] = flen;
          rec_lead[nrec] = lead_ok; rec_trail[nrec] = !ser_bit;
          nrec++;
        end
        cap = 0;
      end
      prev_ser = ser_bit; prev_frame = frame_out; prev_fclk = fclk_out;
      have_prev = 1;
    end
    bit_en = ~bit_en;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    nrec = 0; cap = 0; have_prev = 0; fclk_err = 0;
  endtask

  task automatic push(input logic [13:0] w);
    bit acc = 0;
    bit r;
    in_valid = 1; in_word = w;
    while (!acc) begin
      r = in_ready;
      @(posedge clk);
      acc = r;
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic drain();
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(ser_bit == 0 && frame_out == 0, "R8 outputs low in reset", {ser_bit, frame_out}, 0);
    check(fclk_out == 0, "R8 fclk low in reset", fclk_out, 0);
    check(in_ready == 1, "R8 ready high in reset", in_ready, 1);
    rst_n = 1; nrec = 0; have_prev = 0; fclk_err = 0;
    repeat (20) @(negedge clk);
    check(ser_bit == 0 && frame_out == 0, "R9 idle quiet", {ser_bit, frame_out}, 0);
    check(fclk_err == 0, "R7 fclk toggles while idle", fclk_err, 0);
  endtask

  task automatic t_sh_words();
    logic [13:0] ws [3] = '{14'h2A5C, 14'h3FFF, 14'h0001};
    do_reset();
    mode_cds = 0;
    foreach (ws[i]) begin push(ws[i]); drain(); end
    check(nrec == 3, "R2 three SH slots seen", nrec, 3);
    for (int i = 0; i < 3; i++) begin
      check(rec_word[i] == ws[i], "R3 SH word MSB first", rec_word[i], ws[i]);
      check(rec_len[i] == 6, "R5 SH frame 6 bit-times", rec_len[i], 6);
      check(rec_lead[i] && rec_trail[i], "R3 guard bits low", {rec_lead[i], rec_trail[i]}, 3);
    end
    check(fclk_err == 0, "R7 fclk toggle per bit", fclk_err, 0);
  endtask

  task automatic t_cds_parity();
    logic [13:0] ws [4] = '{14'h1234, 14'h0ABC, 14'h2001, 14'h1FFE};
    do_reset();
    mode_cds = 1;
    foreach (ws[i]) begin push(ws[i]); drain(); end
    check(nrec == 4, "R6 four CDS slots seen", nrec, 4);
    for (int i = 0; i < 4; i++) begin
      check(rec_word[i] == ws[i], "R4 CDS word framed at MSB", rec_word[i], ws[i]);
      check(rec_len[i] == ((i % 2 == 0) ? 4 : 6), "R6 CDS even/odd frame width",
            rec_len[i], (i % 2 == 0) ? 4 : 6);
    end
    mode_cds = 0;
  endtask

  task automatic t_back_to_back();
    logic [13:0] ws [3] = '{14'h3001, 14'h0C30, 14'h2222};
    do_reset();
    mode_cds = 0;
    push(ws[0]);
    repeat (6) @(negedge clk);
    push(ws[1]);
    check(in_ready == 0, "R1 ready low while word held", in_ready, 0);
    push(ws[2]);
    drain(); drain();
    check(nrec == 3, "R9 held words all sent", nrec, 3);
    for (int i = 0; i < 3; i++)
      check(rec_word[i] == ws[i], "R1 no word lost", rec_word[i], ws[i]);
    check(rec_start[1] - rec_start[0] == 16, "R2 slot spacing 16", rec_start[1] - rec_start[0], 16);
    check(rec_start[2] - rec_start[1] == 16, "R9 waits for boundary", rec_start[2] - rec_start[1], 16);
    check(in_ready == 1, "R1 ready returns when empty", in_ready, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sh_words();
        t_cds_parity();
        t_back_to_back();
      end
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog timeout", 0, 1);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule